// File: doc/BRIEF.md
# Blanked PWM Output Steering Core

This block is the digital heart of a fixed-frequency pulse-width modulator. An external oscillator supplies a periodic clock pulse. Each time that pulse falls, the core starts a new drive pulse on one or both of its two outputs. The drive pulse lasts until the first of three events ends it:

- a one-bit flag, raised when the ramp crosses the control level;
- a digital current sample rising above a programmable limit;
- the same sample rising above a higher overcurrent level.

The mode input picks how the outputs are steered. In in-phase mode, both outputs switch together at the clock-pulse rate. In alternating mode, the outputs take turns, so each one runs at half the rate and is idle on every other cycle.

A blanking counter is loaded at reset. For a fixed number of cycles after each pulse start, it hides the ramp flag and the current-limit compare. This lets switching noise at the leading edge pass without ending the pulse. The overcurrent path is never hidden. It forces both outputs low in the same cycle and sets a fault latch, which holds the outputs off until a fault-clear request arrives.

Top module: `pwm_steer_core`

## Requirements
- R1: During and right after reset, both outputs and the fault flag are low, and the steering state selects output A for the first pulse in alternating mode.
- R2: Whenever the clock-pulse input is high, both outputs are low in that same cycle.
- R3: A falling edge of the clock pulse, seen as high in one sampled cycle and low in the next, starts a pulse. The selected outputs are high from the cycle after that sample until the pulse ends. With no other end event, a low phase of L cycles gives L-1 high cycles.
- R4: With the mode input at 0 (in-phase), every pulse drives both outputs identically.
- R5: With the mode input at 1 (alternating), each pulse drives exactly one output. The choice toggles on every clock-pulse falling edge, starting with A after reset.
- R6: Once the pulse is past blanking, a high ramp flag or a current sample strictly above the limit threshold ends it. A pulse that has ended stays off until the next falling edge.
- R7: With a blanking length N, the ramp flag and the current-limit compare are ignored for the first N high cycles of each pulse. If an end event is held throughout, the outputs are high for N+1 cycles.
- R8: The blanking length is captured from its input while reset is asserted, and later changes have no effect. A length of 0 disables blanking, so a held end event gives a single high cycle.
- R9: The overcurrent threshold is L + floor(L/5) for limit L. A sample strictly above it drives both outputs low in the same cycle, even during blanking, and sets the fault flag on the next cycle. A sample equal to it does not trip.
- R10: While the fault flag is set, both outputs stay low across clock pulses. The flag clears only on a fault-clear request (an overcurrent in the same cycle wins) or on reset. After clearing, pulses resume at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; also captures the blanking length |
| clk_pulse_i | input | 1 | Oscillator clock pulse, synchronous to clk |
| mode_alt_i | input | 1 | 0: in-phase outputs, 1: alternating outputs |
| ramp_cmp_i | input | 1 | Ramp crossed the control level |
| isense_i | input | CUR_W | Unsigned current sample |
| lim_thr_i | input | CUR_W | Current-limit threshold |
| blank_len_i | input | BLK_W | Blanking length in cycles, sampled during reset |
| fault_clr_i | input | 1 | Synchronous fault-latch clear request |
| out_a_o | output | 1 | Drive output A |
| out_b_o | output | 1 | Drive output B |
| fault_o | output | 1 | Overcurrent fault latch state |

## Verification
The bench builds the core with CUR_W = 8 and BLK_W = 4. An 8-bit sample lets the limit range reach 200, where the derived overcurrent level still fits. A 4-bit length allows blanking runs of 4 and 5 cycles, which are shorter than the 12-cycle low phases the directed tests use, so the N+1 pulse width is visible. Because both the limit and its 1.2x level fit inside 255, the random stimulus can place samples exactly at, one below and one above each threshold.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    // Output select codes: bit 0 drives output A, bit 1 drives output B.
    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_A    = 2'b01;
    localparam logic [1:0] SEL_B    = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

    // Registered state of the top-level pulse controller.
    typedef struct packed {
        logic clkp;   // clock pulse level from the previous cycle
        logic on;     // a drive pulse is in progress
        logic fault;  // overcurrent latch
    } core_state_t;

    // Registered state of the steering unit.
    typedef struct packed {
        logic       toggle;  // 0: next alternating pulse goes to A
        logic [1:0] sel;     // outputs owned by the current pulse
    } steer_state_t;

endpackage

// File: rtl/pwm_current_cmp.sv
module pwm_current_cmp #(
    parameter int CUR_W = 8
) (
    input  logic [CUR_W-1:0] isense_i,
    input  logic [CUR_W-1:0] lim_thr_i,
    output logic             lim_trip_o,
    output logic             oc_trip_o
);

    // One extra bit so that limit * 1.2 never wraps.
    localparam int EXT_W = CUR_W + 1;

    logic [EXT_W-1:0] lim_ext;
    logic [EXT_W-1:0] oc_thr;
    logic [EXT_W-1:0] sense_ext;

    always_comb begin
        lim_ext    = {1'b0, lim_thr_i};
        sense_ext  = {1'b0, isense_i};
        // Overcurrent level sits a fifth above the limit.
        oc_thr     = lim_ext + (lim_ext / EXT_W'(5));
        lim_trip_o = sense_ext > lim_ext;
        oc_trip_o  = sense_ext > oc_thr;
    end

endmodule

// File: rtl/pwm_blank_timer.sv
module pwm_blank_timer #(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] len_cfg_i,
    input  logic             start_i,
    output logic             active_o
);

    typedef struct packed {
        logic [BLK_W-1:0] len;  // captured during reset
        logic [BLK_W-1:0] cnt;  // cycles of blanking still owed
    } blank_state_t;

    blank_state_t blk_q, blk_d;

    always_comb begin
        blk_d = blk_q;
        if (start_i) begin
            blk_d.cnt = blk_q.len;
        end else if (blk_q.cnt != '0) begin
            blk_d.cnt = blk_q.cnt - BLK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q.len <= len_cfg_i;
            blk_q.cnt <= '0;
        end else begin
            blk_q <= blk_d;
        end
    end

    assign active_o = (blk_q.cnt != '0);

    AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (blk_q.cnt == blk_q.len)); // R7

    AST_BLANK_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && blk_q.cnt != '0) |=> (blk_q.cnt == $past(blk_q.cnt) - BLK_W'(1))); // R7

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(blk_q.len)); // R8

endmodule

// File: rtl/pwm_output_steer.sv
module pwm_output_steer
    import pwm_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_i,
    input  logic       mode_alt_i,
    output logic [1:0] sel_o
);

    steer_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            st_d.toggle = ~st_q.toggle;
            if (mode_alt_i) begin
                st_d.sel = st_q.toggle ? SEL_B : SEL_A;
            end else begin
                st_d.sel = SEL_BOTH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.toggle <= 1'b0;
            st_q.sel    <= SEL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

    AST_STEER_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> (st_q.toggle != $past(st_q.toggle))); // R5

    AST_ALT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && mode_alt_i) |=> ($countones(st_q.sel) == 1)); // R5

    AST_INPHASE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && !mode_alt_i) |=> (st_q.sel == SEL_BOTH)); // R4

endmodule

// File: rtl/pwm_steer_core.sv
module pwm_steer_core
    import pwm_steer_pkg::*;
#(
    parameter int CUR_W = 8,
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_pulse_i,
    input  logic             mode_alt_i,
    input  logic             ramp_cmp_i,
    input  logic [CUR_W-1:0] isense_i,
    input  logic [CUR_W-1:0] lim_thr_i,
    input  logic [BLK_W-1:0] blank_len_i,
    input  logic             fault_clr_i,
    output logic             out_a_o,
    output logic             out_b_o,
    output logic             fault_o
);

    core_state_t core_q, core_d;

    logic       lim_trip;
    logic       oc_trip;
    logic       blank_active;
    logic       fall;
    logic       start;
    logic       end_req;
    logic       drive;
    logic [1:0] sel;

    pwm_current_cmp #(.CUR_W(CUR_W)) i_cmp (
        .isense_i   (isense_i),
        .lim_thr_i  (lim_thr_i),
        .lim_trip_o (lim_trip),
        .oc_trip_o  (oc_trip)
    );

    pwm_blank_timer #(.BLK_W(BLK_W)) i_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_cfg_i (blank_len_i),
        .start_i   (start),
        .active_o  (blank_active)
    );

    pwm_output_steer i_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .mode_alt_i (mode_alt_i),
        .sel_o      (sel)
    );

    always_comb begin
        fall    = core_q.clkp & ~clk_pulse_i;
        start   = fall & ~core_q.fault & ~oc_trip;
        end_req = clk_pulse_i | (~blank_active & (ramp_cmp_i | lim_trip));

        core_d      = core_q;
        core_d.clkp = clk_pulse_i;

        // Fault latch: a trip takes priority over a clear.
        if (oc_trip) begin
            core_d.fault = 1'b1;
        end else if (fault_clr_i) begin
            core_d.fault = 1'b0;
        end

        // Pulse state: only a falling edge can start a pulse.
        if (oc_trip || core_q.fault) begin
            core_d.on = 1'b0;
        end else if (fall) begin
            core_d.on = 1'b1;
        end else if (core_q.on && end_req) begin
            core_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    // The clock pulse and an overcurrent both mask the outputs in the same cycle.
    assign drive   = core_q.on & ~clk_pulse_i & ~core_q.fault & ~oc_trip;
    assign out_a_o = drive & sel[0];
    assign out_b_o = drive & sel[1];
    assign fault_o = core_q.fault;

    AST_PULSE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pulse_i |-> !(out_a_o || out_b_o)); // R2

    AST_FAULT_STOPS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.fault |-> !core_q.on); // R10

    AST_OC_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |=> core_q.fault); // R9

    AST_OC_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> lim_trip); // R9

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_q.on && !fall) |=> !core_q.on); // R6

    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.on && blank_active && !clk_pulse_i && !oc_trip && !core_q.fault)
        |=> core_q.on); // R7

endmodule

// File: tb/test_pwm_steer_core.sv
`timescale 1ns/1ps
module test_pwm_steer_core;

    localparam int CUR_W = 8;
    localparam int BLK_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clk_pulse;
    logic             mode_alt;
    logic             ramp_cmp;
    logic [CUR_W-1:0] isense;
    logic [CUR_W-1:0] lim_thr;
    logic [BLK_W-1:0] blank_len;
    logic             fault_clr;
    logic             out_a;
    logic             out_b;
    logic             fault;

    // Values applied at the next cycle start.
    logic             nx_mode;
    logic             nx_cmp;
    logic [CUR_W-1:0] nx_isense;
    logic [CUR_W-1:0] nx_lim;
    logic             nx_clr;

    int n_tests = 0;
    int n_fail  = 0;
    int cnt_a;
    int cnt_b;

    always #2.5 clk = ~clk;

    pwm_steer_core #(.CUR_W(CUR_W), .BLK_W(BLK_W)) i_pwm_steer_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_pulse_i (clk_pulse),
        .mode_alt_i  (mode_alt),
        .ramp_cmp_i  (ramp_cmp),
        .isense_i    (isense),
        .lim_thr_i   (lim_thr),
        .blank_len_i (blank_len),
        .fault_clr_i (fault_clr),
        .out_a_o     (out_a),
        .out_b_o     (out_b),
        .fault_o     (fault)
    );

    function automatic int oc_level(input int lim);
        return lim + lim / 5;
    endfunction

    // Behavioural reference built from the requirements.
    logic       m_clkp;
    logic       m_on;
    logic       m_fault;
    logic       m_tog;
    logic [1:0] m_sel;
    int         m_cnt;
    int         m_len;

    always @(posedge clk or negedge rst_n) begin : ref_model
        logic f;
        logic oc;
        logic lt;
        if (!rst_n) begin
            m_clkp  <= 1'b0;
            m_on    <= 1'b0;
            m_fault <= 1'b0;
            m_tog   <= 1'b0;
            m_sel   <= 2'b00;
            m_cnt   <= 0;
            m_len   <= int'(blank_len);
        end else begin
            f  = m_clkp && !clk_pulse;
            oc = int'(isense) > oc_level(int'(lim_thr));
            lt = isense > lim_thr;
            m_clkp <= clk_pulse;
            if (oc) m_fault <= 1'b1;
            else if (fault_clr) m_fault <= 1'b0;
            if (f) begin
                m_tog <= !m_tog;
                m_sel <= mode_alt ? (m_tog ? 2'b10 : 2'b01) : 2'b11;
            end
            if (oc || m_fault) m_on <= 1'b0;
            else if (f) m_on <= 1'b1;
            else if (m_on && (clk_pulse || (m_cnt == 0 && (ramp_cmp || lt)))) m_on <= 1'b0;
            if (f && !m_fault && !oc) m_cnt <= m_len;
            else if (m_cnt != 0) m_cnt <= m_cnt - 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic p, input string tag);
        logic drv;
        @(posedge clk);
        #1;
        clk_pulse = p;
        mode_alt  = nx_mode;
        ramp_cmp  = nx_cmp;
        isense    = nx_isense;
        lim_thr   = nx_lim;
        fault_clr = nx_clr;
        @(negedge clk);
        drv = m_on && !clk_pulse && !m_fault && (int'(isense) <= oc_level(int'(lim_thr)));
        chk(tag, int'({out_a, out_b, fault}), int'({drv && m_sel[0], drv && m_sel[1], m_fault}));
        if (out_a) cnt_a++;
        if (out_b) cnt_b++;
    endtask

    task automatic period(input int h, input int l, input string tag);
        cnt_a = 0;
        cnt_b = 0;
        for (int i = 0; i < h; i++) cyc(1'b1, tag);
        for (int i = 0; i < l; i++) cyc(1'b0, tag);
    endtask

    task automatic do_reset(input int len);
        @(posedge clk);
        #1;
        rst_n     = 1'b0;
        blank_len = BLK_W'(len);
        clk_pulse = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'({out_a, out_b, fault}), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        rst_n = 1'b0; clk_pulse = 1'b0; mode_alt = 1'b0; ramp_cmp = 1'b0;
        isense = '0; lim_thr = 8'd100; blank_len = 4'd4; fault_clr = 1'b0;
        nx_mode = 1'b1; nx_cmp = 1'b0; nx_isense = '0; nx_lim = 8'd100; nx_clr = 1'b0;
        do_reset(4);

        // R5 / R3: alternating, A first then B, L-1 high cycles.
        period(3, 12, "R3");
        chk("R3", cnt_a, 11);
        chk("R5", cnt_b, 0);
        period(3, 12, "R5");
        chk("R5", cnt_a, 0);
        chk("R5", cnt_b, 11);

        // R4 / R7: in-phase, ramp flag held, blanking N=4 gives 5 cycles.
        nx_mode = 1'b0; nx_cmp = 1'b1;
        period(3, 12, "R7");
        chk("R7", cnt_a, 5);
        chk("R4", cnt_b, cnt_a);

        // R6: current just above limit ends pulse after blanking.
        nx_cmp = 1'b0; nx_isense = 8'd110;
        period(3, 12, "R6");
        chk("R6", cnt_a, 5);
        // R9: sample equal to overcurrent level (120) does not trip.
        nx_isense = 8'd120;
        period(3, 12, "R9");
        chk("R9", cnt_a, 5);
        chk("R9", int'(fault), 0);

        // R9: overcurrent during blanking masks at once and latches.
        nx_isense = '0;
        for (int i = 0; i < 3; i++) cyc(1'b1, "R9");
        cyc(1'b0, "R9");
        cyc(1'b0, "R3");
        chk("R3", int'({out_a, out_b}), 3);
        nx_isense = 8'd121;
        cyc(1'b0, "R9");
        chk("R9", int'({out_a, out_b}), 0);
        nx_isense = '0;
        cyc(1'b0, "R9");
        chk("R9", int'(fault), 1);
        for (int i = 0; i < 8; i++) cyc(1'b0, "R10");

        // R10: fault holds outputs off over whole periods, then clears.
        period(3, 12, "R10");
        chk("R10", cnt_a + cnt_b, 0);
        chk("R10", int'(fault), 1);
        cnt_a = 0; cnt_b = 0;
        nx_clr = 1'b1;
        cyc(1'b1, "R10");
        nx_clr = 1'b0;
        cyc(1'b1, "R10");
        chk("R10", int'(fault), 0);
        cyc(1'b1, "R10");
        for (int i = 0; i < 12; i++) cyc(1'b0, "R10");
        chk("R10", cnt_a, 11);

        // R8: zero length disables blanking; later input changes ignored.
        do_reset(0);
        nx_mode = 1'b0; nx_cmp = 1'b1;
        period(3, 12, "R8");
        chk("R8", cnt_a, 1);
        blank_len = 4'd7;
        period(3, 12, "R8");
        chk("R8", cnt_a, 1);
        chk("R2", int'({out_a, out_b}), 0);

        // Random mix against the reference.
        do_reset(5);
        for (int p = 0; p < 150; p++) begin
            int h;
            int l;
            int lim;
            h   = 1 + int'($urandom % 4);
            l   = 2 + int'($urandom % 18);
            lim = 20 + int'($urandom % 181);
            nx_mode = 1'($urandom % 2);
            nx_lim  = CUR_W'(lim);
            for (int c = 0; c < h + l; c++) begin
                int sel;
                nx_cmp = ($urandom % 8) == 0;
                nx_clr = ($urandom % 10) == 0;
                sel = int'($urandom % 10);
                if (sel < 5)       nx_isense = CUR_W'($urandom % lim);
                else if (sel < 7)  nx_isense = CUR_W'(lim - 1 + int'($urandom % 3));
                else if (sel == 7) nx_isense = CUR_W'(oc_level(lim) - 1 + int'($urandom % 3));
                else               nx_isense = CUR_W'($urandom % 256);
                cyc(c < h, "R6");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule